// File: doc/BRIEF.md
# TDM Frame Multiplexer with Sync Word

The block packs three 8-bit parallel channels into a single time-division multiplexed serial stream. An internal clock divider sets the bit rate. Every frame has four 8-bit slots. Slot 0 carries a constant alignment pattern derived from a 7-chip Barker sequence, and slots 1 to 3 carry the three channels in a fixed order. A downstream receiver can find the frame boundary by correlating against the alignment pattern and then split the stream back into its three channels.

The channel words are captured into the output shift register on the same clock edge that emits the first alignment bit. Inputs may therefore change at any time without corrupting the frame being sent. A frame-start strobe marks the first bit period of each frame. A one-cycle bit-valid strobe marks every clock in which a new bit appears on the serial output.

Top module: `tdm_framer`

## Requirements
- R1: While reset is high, `ser_out`, `frame_start` and `bit_valid` are all 0. The first bit presented after reset is bit 7 of the alignment word (value 1), and `frame_start` is 1 with it.
- R2: With the default divider ratio of 4, `bit_valid` is high for exactly one clock and pulses every 4 clocks.
- R3: A frame is 32 bits sent MSB first, in this order: alignment word 8'hE4 (8'b11100100), then `ch_a_in`, then `ch_b_in`, then `ch_c_in`.
- R4: `frame_start` goes high with the first bit of the alignment word. It stays high for that whole bit period and falls when the next bit is presented, so it is high for exactly one bit of every 32.
- R5: All three channel inputs are sampled on the clock edge that presents the first alignment bit. Changes made later in the frame do not alter the frame in progress and appear in the next frame.
- R6: `ser_out` and `frame_start` change only in cycles where `bit_valid` is 1.
- R7: Asserting reset in the middle of a frame abandons that frame. After release, a new frame starts with the alignment word and freshly sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a_in | input | 8 | Channel in slot 1 (converter data) |
| ch_b_in | input | 8 | Channel in slot 2 (first switch bank) |
| ch_c_in | input | 8 | Channel in slot 3 (second switch bank) |
| ser_out | output | 1 | Serial multiplexed bit stream |
| frame_start | output | 1 | High during the first bit period of each frame |
| bit_valid | output | 1 | One-clock pulse when a new bit is presented |

## Verification
Sampling the channel inputs and emitting the first alignment bit happen on the same edge. That edge is also where the final bit of the previous frame gives way. To provoke this, the bench drives the next frame's channel values during the last bit period of the current frame. It also drives deliberately wrong values a few bits into each frame. It then reassembles every 32-bit frame from the serial output and compares it against the alignment word plus the values that were present at the frame boundary. Any late-arriving junk or early capture shows up as a word mismatch. A reset that lands mid-frame collides with the slot and bit counters while they are advancing. The bench judges it by requiring that the next bit after release carries the frame-start strobe and a full, correct frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned FRAME_W = WORD_W * SLOTS;
  // 7-chip Barker sequence 1110010 with a trailing 0
  localparam logic [WORD_W-1:0] SYNC_WORD = 8'b11100100;
endpackage

// File: rtl/tdm_rate_div.sv
module tdm_rate_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic bit_en
);
  localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);

  generate
    if (DIV < 2) begin : g_every_clk
      always_ff @(posedge clk) begin
        bit_en <= !rst;
      end
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt    <= '0;
          bit_en <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt    <= '0;
          bit_en <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          bit_en <= 1'b0;
        end
      end

      // R2: enable is a single-cycle pulse
      assert_en_single_R2: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> !bit_en);
    end
  endgenerate
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SLOTS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic first_bit
);
  localparam int unsigned BW = (WORD_W < 2) ? 1 : $clog2(WORD_W);
  localparam int unsigned SW = (SLOTS < 2) ? 1 : $clog2(SLOTS);

  logic [BW-1:0] bit_idx;
  logic [SW-1:0] slot_idx;
  logic          bit_wrap;

  assign bit_wrap  = (bit_idx == BW'(WORD_W - 1));
  assign first_bit = (bit_idx == '0) && (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (bit_en) begin
      if (bit_wrap) begin
        bit_idx <= '0;
        if (slot_idx == SW'(SLOTS - 1)) slot_idx <= '0;
        else                            slot_idx <= slot_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R3: slot advances only at a word boundary
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!bit_en || !bit_wrap) |=> $stable(slot_idx));
  // R7: counters restart from the frame origin after reset
  assert_origin_R7: assert property (@(posedge clk)
    $past(rst) |-> first_bit);
endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               first_bit,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               ser_out,
  output logic               frame_start,
  output logic               bit_valid
);
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      ser_out     <= 1'b0;
      frame_start <= 1'b0;
      bit_valid   <= 1'b0;
    end else begin
      bit_valid <= bit_en;
      if (bit_en) begin
        if (first_bit) begin
          ser_out     <= frame_in[FRAME_W-1];
          sh          <= {frame_in[FRAME_W-2:0], 1'b0};
          frame_start <= 1'b1;
        end else begin
          ser_out     <= sh[FRAME_W-1];
          sh          <= {sh[FRAME_W-2:0], 1'b0};
          frame_start <= 1'b0;
        end
      end
    end
  end

  // R1: the frame origin raises frame_start on the next clock
  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && first_bit) |=> (frame_start && bit_valid));
  // R4: frame_start rises only together with a sync MSB of 1
  assert_fs_sync_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_start) |-> (ser_out && bit_valid));
  // R6: serial line is quiet between bit strobes
  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (ser_out != $past(ser_out)) |-> bit_valid);
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ch_a_in,
  input  logic [WORD_W-1:0] ch_b_in,
  input  logic [WORD_W-1:0] ch_c_in,
  output logic              ser_out,
  output logic              frame_start,
  output logic              bit_valid
);
  logic               bit_en;
  logic               first_bit;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {SYNC_WORD, ch_a_in, ch_b_in, ch_c_in};

  tdm_rate_div #(.DIV(DIV)) u_div (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en)
  );

  tdm_frame_ctr #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .first_bit (first_bit)
  );

  tdm_word_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .first_bit   (first_bit),
    .frame_in    (frame_word),
    .ser_out     (ser_out),
    .frame_start (frame_start),
    .bit_valid   (bit_valid)
  );

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R2: bit_valid is one clock wide
      assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);
    end
  endgenerate

  // R4: frame_start holds across the bit period
  assert_fs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(frame_start));
  // R1: outputs are cleared in the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !frame_start && !bit_valid));
endmodule

// File: tb/tdm_framer_bench.sv
`timescale 1ns/1ps
module tdm_framer_bench;
  localparam int unsigned DIV = 4;
  localparam int unsigned NV  = 6;
  localparam logic [23:0] VEC [NV] = '{
    24'hA53C0F, 24'h000000, 24'hFFFFFF, 24'h80017E, 24'h123456, 24'hE4E4E4
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ch_a_in = '0, ch_b_in = '0, ch_c_in = '0;
  logic       ser_out, frame_start, bit_valid;

  int total = 0;
  int fails = 0;
  logic prev_so;
  int glitches;

  always #2.5 clk = ~clk;

  tdm_framer #(.DIV(DIV)) u_tdm_framer (
    .clk, .rst, .ch_a_in, .ch_b_in, .ch_c_in,
    .ser_out, .frame_start, .bit_valid
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [23:0] v);
    {ch_a_in, ch_b_in, ch_c_in} = v;
  endtask

  task automatic next_bit(output logic b, output logic fs,
                          output logic fs_before, output int gap);
    gap = 0;
    fs_before = frame_start;
    do begin
      fs_before = frame_start;
      @(negedge clk);
      gap++;
      if (ser_out != prev_so && !bit_valid) glitches++;
      prev_so = ser_out;
    end while (!bit_valid && gap < 1000);
    b  = ser_out;
    fs = frame_start;
  endtask

  task automatic run_frame(input logic [23:0] exp, input logic [23:0] nxt,
                           input bit after_rst);
    logic [31:0] got = '0;
    logic [31:0] fs_pat = '0;
    int gap_bad = 0;
    logic b, fs, fsb;
    int gap;
    bit hold_bad = 0;
    glitches = 0;
    prev_so = ser_out;
    for (int i = 0; i < 32; i++) begin
      next_bit(b, fs, fsb, gap);
      got    = {got[30:0], b};
      fs_pat = {fs_pat[30:0], fs};
      if (!(after_rst && i == 0) && gap != DIV) gap_bad++;
      if (i == 1 && !fsb) hold_bad = 1;
      if (i == 3) drive(~nxt);
      if (i == 31) drive(nxt);
    end
    check(got == {8'hE4, exp}, "R3/R5 frame content", got, {8'hE4, exp});
    check(fs_pat == 32'h8000_0000, "R4 frame_start pattern", fs_pat, 32'h8000_0000);
    check(!hold_bad, "R4 frame_start held for full bit", {31'd0, hold_bad}, 32'd0);
    check(gap_bad == 0, "R2 bit spacing", gap_bad, 32'd0);
    check(glitches == 0, "R6 change outside bit_valid", glitches, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int pulses;
    drive(VEC[0]);
    repeat (5) @(negedge clk);
    check({ser_out, frame_start, bit_valid} == 3'b000, "R1 outputs in reset",
          {29'd0, ser_out, frame_start, bit_valid}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++)
      run_frame(VEC[k], VEC[(k + 1) % NV], k == 0);

    // R2: bit_valid width over a window
    pulses = 0;
    for (int c = 0; c < 4 * DIV; c++) begin
      @(negedge clk);
      if (bit_valid) pulses++;
    end
    check(pulses == 4, "R2 pulses per 16 clocks", pulses, 32'd4);

    // R7: reset mid-frame
    repeat (7 * DIV) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({ser_out, frame_start, bit_valid} == 3'b000, "R7 outputs in mid-frame reset",
          {29'd0, ser_out, frame_start, bit_valid}, 32'd0);
    drive(24'h5AC399);
    rst = 1'b0;
    run_frame(24'h5AC399, 24'h5AC399, 1'b1);
    run_frame(24'h5AC399, 24'h0F0F0F, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule